// File: doc/BRIEF.md
# 10BASE-T Link Integrity Monitor

This block decides whether a twisted-pair 10 Mb/s link may carry outgoing frames. It watches two decoded receive events. One is a single-cycle strobe for each valid incoming link pulse. The other is a level that is high while frame data is arriving. From these it keeps a link-up flag, which gates transmission. The first link pulse brings the link up. After that, any link pulse or any receive data keeps it up. When both stay quiet for a full loss interval, the link drops. The block then gives a one-cycle failure pulse and, if auto-negotiation is enabled, a one-cycle request to restart it.

A bypass configuration input forces transmit on whatever the link state is, and it suppresses the failure reporting. An independent generator asks for an outgoing link pulse at a fixed interval whether or not the link is up. Both the interval and the loss time are parameters counted in clock cycles. With a 50 MHz clock, the defaults give 16 ms and 100 ms.

Top module: `lit_link_monitor`

## Requirements
- R1: After reset `link_up_o`, `link_fail_o` and `aneg_restart_o` are 0 and `tx_en_o` equals `test_bypass_i`.
- R2: A `link_pulse_i` strobe sampled at a clock edge sets `link_up_o` and `tx_en_o` to 1 from that edge on.
- R3: `rx_active_i` while the link is down does not bring the link up.
- R4: Every `link_pulse_i` strobe restarts the loss timer, so pulses spaced less than `LOSS_CYCLES` apart keep the link up.
- R5: The loss timer is held at its full value for as long as `rx_active_i` is 1, so held receive activity keeps the link up indefinitely.
- R6: When `LOSS_CYCLES` edges pass with neither input active after the last active edge, `link_up_o` and `tx_en_o` fall at that edge and `link_fail_o` is 1 for exactly one cycle.
- R7: `aneg_restart_o` pulses for one cycle together with `link_fail_o` when `aneg_en_i` is 1, and stays 0 when it is 0.
- R8: With `test_bypass_i` at 1, `tx_en_o` is 1 whatever the link state, and no failure or restart pulse is produced even when the link drops.
- R9: `pulse_req_o` is a one-cycle pulse repeating every `PULSE_PERIOD` cycles, whatever the link state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_pulse_i | input | 1 | One-cycle strobe per valid received link pulse |
| rx_active_i | input | 1 | High while receive data is arriving |
| test_bypass_i | input | 1 | 1 forces transmit on and mutes failure reporting |
| aneg_en_i | input | 1 | Auto-negotiation enabled |
| tx_en_o | output | 1 | Transmit permitted |
| link_up_o | output | 1 | Link integrity state |
| link_fail_o | output | 1 | One-cycle pulse on link loss |
| aneg_restart_o | output | 1 | One-cycle request to restart auto-negotiation |
| pulse_req_o | output | 1 | Periodic request for an outgoing link pulse |

## Verification
Link-up is registered, so it shows one edge after the strobe that causes it. The loss timer reloads on the last active edge E, and the link falls at edge E+`LOSS_CYCLES` with the failure and restart pulses on that same edge. The bench drives and samples at falling edges. It counts exactly `LOSS_CYCLES`-1 edges to confirm the link is still up, then one more edge to see it drop, and one more to see the pulses clear. Pulse-request checks measure the spacing between consecutive requests and do not count from reset.

// File: rtl/lit_pkg.sv
package lit_pkg;
  typedef enum logic {
    LNK_DOWN = 1'b0,
    LNK_UP   = 1'b1
  } lnk_state_e;
endpackage

// File: rtl/lit_pulse_gen.sv
module lit_pulse_gen #(
  parameter int unsigned PERIOD = 800000
) (
  input  logic clk,
  input  logic rst_n,
  output logic req_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          req_q, req_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    req_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/lit_loss_timer.sv
module lit_loss_timer #(
  parameter int unsigned LOSS = 5000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic expired_o
);
  localparam int unsigned TW = $clog2(LOSS + 1);
  localparam logic [TW-1:0] FULL = TW'(LOSS);

  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;

  always_comb begin
    tmr_en    = restart_i || (tmr_q != '0);
    tmr_d     = restart_i ? FULL : tmr_q - 1'b1;
    expired_o = !restart_i && (tmr_q == TW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end
endmodule

// File: rtl/lit_link_fsm.sv
module lit_link_fsm
  import lit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  input  logic expired_i,
  input  logic bypass_i,
  input  logic aneg_en_i,
  output logic link_up_o,
  output logic fail_o,
  output logic restart_o
);
  lnk_state_e st_q, st_d;
  logic       fail_q, fail_d;
  logic       rst_req_q, rst_req_d;
  logic       drop;

  always_comb begin
    drop      = (st_q == LNK_UP) && expired_i && !pulse_i;
    st_d      = st_q;
    if (pulse_i) begin
      st_d = LNK_UP;
    end else if (drop) begin
      st_d = LNK_DOWN;
    end
    fail_d    = drop && !bypass_i;
    rst_req_d = fail_d && aneg_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= LNK_DOWN;
      fail_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      fail_q    <= fail_d;
      rst_req_q <= rst_req_d;
    end
  end

  assign link_up_o = (st_q == LNK_UP);
  assign fail_o    = fail_q;
  assign restart_o = rst_req_q;
endmodule

// File: rtl/lit_link_monitor.sv
module lit_link_monitor #(
  parameter int unsigned LOSS_CYCLES  = 5000000,
  parameter int unsigned PULSE_PERIOD = 800000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_pulse_i,
  input  logic rx_active_i,
  input  logic test_bypass_i,
  input  logic aneg_en_i,
  output logic tx_en_o,
  output logic link_up_o,
  output logic link_fail_o,
  output logic aneg_restart_o,
  output logic pulse_req_o
);
  logic activity;
  logic expired;
  logic up;

  assign activity = link_pulse_i || rx_active_i;

  lit_pulse_gen #(.PERIOD(PULSE_PERIOD)) u_pgen (
    .clk   (clk),
    .rst_n (rst_n),
    .req_o (pulse_req_o)
  );

  lit_loss_timer #(.LOSS(LOSS_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (activity),
    .expired_o (expired)
  );

  lit_link_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_i   (link_pulse_i),
    .expired_i (expired),
    .bypass_i  (test_bypass_i),
    .aneg_en_i (aneg_en_i),
    .link_up_o (up),
    .fail_o    (link_fail_o),
    .restart_o (aneg_restart_o)
  );

  assign link_up_o = up;
  assign tx_en_o   = up || test_bypass_i;
endmodule

// File: rtl/lit_link_monitor_chk.sv
module lit_link_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic link_pulse_i,
  input logic rx_active_i,
  input logic test_bypass_i,
  input logic aneg_en_i,
  input logic tx_en_o,
  input logic link_up_o,
  input logic link_fail_o,
  input logic aneg_restart_o,
  input logic pulse_req_o
);
  // R2
  pulse_raises_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_pulse_i |=> (link_up_o && tx_en_o));

  // R3
  rise_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up_o) |-> $past(link_pulse_i));

  // R5
  rx_holds_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active_i && link_up_o) |=> link_up_o);

  // R6
  fail_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail_o |-> (!link_up_o && $past(link_up_o)));

  // R6
  fail_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail_o |=> !link_fail_o);

  // R7
  restart_with_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aneg_restart_o |-> (link_fail_o && $past(aneg_en_i)));

  // R8
  bypass_mutes_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_bypass_i |=> !link_fail_o);

  // R9
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_req_o |=> !pulse_req_o);
endmodule

bind lit_link_monitor lit_link_monitor_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .link_pulse_i   (link_pulse_i),
  .rx_active_i    (rx_active_i),
  .test_bypass_i  (test_bypass_i),
  .aneg_en_i      (aneg_en_i),
  .tx_en_o        (tx_en_o),
  .link_up_o      (link_up_o),
  .link_fail_o    (link_fail_o),
  .aneg_restart_o (aneg_restart_o),
  .pulse_req_o    (pulse_req_o)
);

// File: tb/test_lit_link_monitor.sv
module test_lit_link_monitor;
  localparam int unsigned LOSS  = 40;
  localparam int unsigned PER   = 25;

  logic clk, rst_n;
  logic link_pulse_i, rx_active_i, test_bypass_i, aneg_en_i;
  logic tx_en_o, link_up_o, link_fail_o, aneg_restart_o, pulse_req_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  lit_link_monitor #(.LOSS_CYCLES(LOSS), .PULSE_PERIOD(PER)) i_lit_link_monitor (
    .clk(clk), .rst_n(rst_n), .link_pulse_i(link_pulse_i), .rx_active_i(rx_active_i),
    .test_bypass_i(test_bypass_i), .aneg_en_i(aneg_en_i), .tx_en_o(tx_en_o),
    .link_up_o(link_up_o), .link_fail_o(link_fail_o), .aneg_restart_o(aneg_restart_o),
    .pulse_req_o(pulse_req_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input bit byp);
    rst_n = 1'b0; link_pulse_i = 0; rx_active_i = 0;
    test_bypass_i = byp; aneg_en_i = 1;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic raise_link();
    link_pulse_i = 1'b1;
    step(1);
    link_pulse_i = 1'b0;
  endtask

  // Called right after the last active edge E; link must fall at E+LOSS.
  task automatic expect_drop(input bit exp_fail, input bit exp_rst, input string tag);
    step(LOSS - 1);
    check(link_up_o == 1, {tag, " up before timeout"}, link_up_o, 1);
    step(1);
    check(link_up_o == 0, {tag, " down at timeout"}, link_up_o, 0);
    check(link_fail_o == exp_fail, {tag, " fail pulse"}, link_fail_o, exp_fail);
    check(aneg_restart_o == exp_rst, {tag, " restart pulse"}, aneg_restart_o, exp_rst);
    step(1);
    check(link_fail_o == 0, {tag, " fail one cycle"}, link_fail_o, 0);
    check(aneg_restart_o == 0, {tag, " restart one cycle"}, aneg_restart_o, 0);
  endtask

  task automatic t_reset();
    do_reset(0);
    check(link_up_o == 0, "R1 link_up", link_up_o, 0);
    check(tx_en_o == 0, "R1 tx_en", tx_en_o, 0);
    check(link_fail_o == 0 && aneg_restart_o == 0, "R1 pulses", link_fail_o, 0);
    do_reset(1);
    check(tx_en_o == 1, "R1 tx_en with bypass", tx_en_o, 1);
  endtask

  task automatic t_rx_only();
    do_reset(0);
    rx_active_i = 1'b1;
    step(10);
    rx_active_i = 1'b0;
    check(link_up_o == 0, "R3 rx alone", link_up_o, 0);
    check(tx_en_o == 0, "R3 tx stays off", tx_en_o, 0);
  endtask

  task automatic t_pulses();
    do_reset(0);
    raise_link();
    check(link_up_o == 1, "R2 link up", link_up_o, 1);
    check(tx_en_o == 1, "R2 tx_en", tx_en_o, 1);
    for (int k = 0; k < 3; k++) begin
      step(LOSS - 6);
      raise_link();
      check(link_up_o == 1, "R4 kept up by pulses", link_up_o, 1);
    end
    aneg_en_i = 1'b1;
    expect_drop(1, 1, "R6 R7 pulse loss");
    check(tx_en_o == 0, "R6 tx off after loss", tx_en_o, 0);
  endtask

  task automatic t_rx_hold();
    do_reset(0);
    raise_link();
    rx_active_i = 1'b1;
    step(3 * LOSS);
    check(link_up_o == 1, "R5 held by rx", link_up_o, 1);
    rx_active_i = 1'b0;
    aneg_en_i = 1'b0;
    expect_drop(1, 0, "R5 R7 rx loss no aneg");
  endtask

  task automatic t_bypass();
    do_reset(1);
    check(tx_en_o == 1, "R8 tx forced while down", tx_en_o, 1);
    raise_link();
    expect_drop(0, 0, "R8 bypass loss");
    check(tx_en_o == 1, "R8 tx forced after loss", tx_en_o, 1);
  endtask

  task automatic t_pulse_req(input bit with_link, input string tag);
    int w;
    int gap;
    do_reset(0);
    if (with_link) begin
      rx_active_i = 1'b1;
      raise_link();
    end
    w = 0;
    while (!pulse_req_o && w < PER + 3) begin step(1); w++; end
    check(pulse_req_o == 1, {tag, " request seen"}, pulse_req_o, 1);
    step(1);
    check(pulse_req_o == 0, {tag, " request width"}, pulse_req_o, 0);
    gap = 1;
    while (!pulse_req_o && gap < PER + 3) begin step(1); gap++; end
    check(gap == PER, {tag, " request period"}, gap, PER);
    rx_active_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; link_pulse_i = 0; rx_active_i = 0; test_bypass_i = 0; aneg_en_i = 0;
    t_reset();
    t_rx_only();
    t_pulses();
    t_rx_hold();
    t_bypass();
    t_pulse_req(0, "R9 link down");
    t_pulse_req(1, "R9 link up");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule